// File: doc/BRIEF.md
# APB Single-Byte Serial Port

This block is a serial port that sits on an APB bus as a slave. Software writes one byte at a time into a transmit holding register. A transmit engine sends it on a serial output line as a frame of 8 data bits, no parity and 1 stop bit. A receive engine watches the serial input line and places each complete byte in a receive holding register, which software reads back over APB. Each direction holds exactly one byte. When a new byte arrives while the previous one is still held, the new byte replaces it and a sticky overrun flag records the loss.

Software sets the bit rate with a 20-bit divider: each serial bit lasts that many bus-clock cycles. Any divider value below 16 is invalid, and both engines stay idle while it is invalid. Four interrupt lines report four events: transmit done, byte received, transmit overrun and receive overrun. A fifth line is high whenever any of the four is high. The two overrun interrupt bits are not stored. They are the live AND of the overrun flags and their enables, so acknowledging them clears the flags themselves.

The transmit engine is a four-state machine. TX_IDLE goes to TX_START when transmission is enabled, a byte is held and the divider is valid. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_STOP after the eighth bit. TX_STOP goes to TX_IDLE after one bit time and reports completion.

The receive engine has the same four states. RX_IDLE goes to RX_START on a falling edge of the synchronised input while the divider is valid. RX_START goes to RX_DATA if the line is still low at mid-bit, and otherwise aborts to RX_IDLE. RX_DATA goes to RX_STOP after eight centre samples. RX_STOP returns to RX_IDLE and delivers the byte only if the stop sample is high.

Top module: `apb_byte_uart`

## Requirements
- R1: After reset, every register reads zero, ser_out is high and all five interrupt outputs are low. The register offsets are: byte register 0x00, flags 0x04, config 0x08, interrupt register 0x0C, divider 0x10.
- R2: Offsets 0xFD0 to 0xFFC are read-only identification words. Word i (i = (offset - 0xFD0)/4, 0 to 11) reads ID_SEED + i, which is 0xA0 + i by default. Writes there change nothing. Any other unmapped offset reads zero.
- R3: The config register keeps only bits 6:0 of a write. Bit0 enables transmit, bit1 enables receive, bit2 enables the transmit interrupt, bit3 enables the receive interrupt, bit4 enables the transmit-overrun interrupt and bit5 enables the receive-overrun interrupt. Bit6 is stored and has no effect.
- R4: The divider register keeps bits 19:0 of a write. While its value is below 16, a held byte is not sent and ser_out stays high.
- R5: A transmit frame is a low start bit, 8 data bits LSB first and a high stop bit, each lasting divider cycles. A frame starts only while transmit is enabled and flags bit0 (transmit full) is set.
- R6: At the end of a frame, transmit full clears. If config bit2 is set, interrupt bit0 is set and stays set until a 1 is written to interrupt bit0.
- R7: Writing the byte register while transmit full is set sets flags bit2 (transmit overrun), and the new byte replaces the held byte. Writing 1 to flags bit2 clears the flag.
- R8: A received frame is a low start bit that is still low at mid-bit, 8 bits LSB first and a stop bit that must be high; any other frame is dropped. A start pulse shorter than half a bit is ignored. A good frame loads the receive register, sets flags bit1 (receive full) and, if config bit3 is set, sets interrupt bit1, which is cleared by writing 1 to it. Reading the byte register returns the byte and clears receive full.
- R9: While config bit1 is clear, a received frame changes neither the receive register nor the flags.
- R10: A byte received while receive full is set sets flags bit3 (receive overrun) and overwrites the receive register.
- R11: Interrupt bits 2 and 3 read as flags bit2 AND config bit4, and flags bit3 AND config bit5. Writing 1 to interrupt bit 2 or bit 3 clears the matching overrun flag.
- R12: irq_tx, irq_rx, irq_tx_ovr and irq_rx_ovr equal interrupt bits 0 to 3. irq_any is high exactly when any of those bits is set.
- R13: Every APB access completes in its first access cycle, because pready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and bit-timing clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant high |
| ser_out | output | 1 | Serial transmit line, idles high |
| ser_in | input | 1 | Serial receive line |
| irq_tx | output | 1 | Transmit-done interrupt |
| irq_rx | output | 1 | Byte-received interrupt |
| irq_tx_ovr | output | 1 | Transmit-overrun interrupt |
| irq_rx_ovr | output | 1 | Receive-overrun interrupt |
| irq_any | output | 1 | OR of the four interrupt lines |

## Verification
All 256 byte values are sent with the serial output looped back to the input. Each frame is decoded from the line by the bench and also read back from the receive register, so a bit-order, bit-count or stop-bit fault shows up as a mismatch in one of the two paths for some value. Separate runs cover the rest:
- The start bit is timed at two divider settings, which separates an off-by-one in the bit counter from a correct bit length.
- Frames with a bad stop bit, a short glitch and a second byte before a read separate the drop, reject and overrun paths.
- Held bytes are queued while transmit is disabled or the divider is invalid, which tells the replacement and idle rules apart from immediate sending.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    localparam int BUS_AW = 12;
    localparam int BUS_DW = 32;

    // word indices (paddr[11:2]) of the mapped registers
    localparam logic [9:0] W_BYTE  = 10'h000;
    localparam logic [9:0] W_FLAGS = 10'h001;
    localparam logic [9:0] W_CFG   = 10'h002;
    localparam logic [9:0] W_IRQ   = 10'h003;
    localparam logic [9:0] W_DIV   = 10'h004;
    localparam logic [9:0] W_ID0   = 10'h3F4;

    // config bit positions
    localparam int C_TX_EN  = 0;
    localparam int C_RX_EN  = 1;
    localparam int C_TX_IE  = 2;
    localparam int C_RX_IE  = 3;
    localparam int C_TXO_IE = 4;
    localparam int C_RXO_IE = 5;
    localparam int CFG_W    = 7;

endpackage

// File: rtl/uart_tx_fsm.sv
module uart_tx_fsm
    import byte_uart_pkg::*;
#(
    parameter int DIV_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [7:0]       din,
    input  logic [DIV_W-1:0] div,
    output logic             ser_out,
    output logic             done
);
    localparam logic [DIV_W-1:0] DIV_ONE = 1;

    tx_state_t        state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       idx_q;
    logic [7:0]       sh_q;
    logic             bit_end;

    assign bit_end = (cnt_q == div - DIV_ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (go) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && idx_q == 3'd7) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_IDLE) begin
                cnt_q <= '0;
                idx_q <= '0;
                if (go) sh_q <= din;
            end else if (bit_end) begin
                cnt_q <= '0;
                if (state_q == TX_DATA) begin
                    sh_q  <= {1'b0, sh_q[7:1]};
                    idx_q <= idx_q + 3'd1;
                end
            end else begin
                cnt_q <= cnt_q + DIV_ONE;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            TX_IDLE:  ser_out = 1'b1;
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = sh_q[0];
            TX_STOP:  ser_out = 1'b1;
        endcase
        done = (state_q == TX_STOP) && bit_end;
    end

endmodule

// File: rtl/uart_rx_fsm.sv
module uart_rx_fsm
    import byte_uart_pkg::*;
#(
    parameter int DIV_W  = 20,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    output logic             valid,
    output logic [7:0]       dout
);
    localparam logic [DIV_W-1:0] DIV_ONE = 1;

    rx_state_t        state_q, state_d;
    logic [SYNC_N:0]  sync_q;
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       idx_q;
    logic [7:0]       sh_q;
    logic             valid_q;
    logic             line, fall, bit_end, mid;

    assign line    = sync_q[SYNC_N-1];
    assign fall    = sync_q[SYNC_N] & ~line;
    assign bit_end = (cnt_q == div - DIV_ONE);
    assign mid     = (cnt_q == (div >> 1));

    // synchroniser chain plus one delayed copy for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_N-1:0], ser_in};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (fall && enable) state_d = RX_START;
            RX_START: if (mid) state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_end && idx_q == 3'd7) state_d = RX_STOP;
            RX_STOP:  if (bit_end) state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= (state_q == RX_STOP) && bit_end && line;
            unique case (state_q)
                RX_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                RX_START: cnt_q <= mid ? '0 : cnt_q + DIV_ONE;
                RX_DATA: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        sh_q  <= {line, sh_q[7:1]};
                        idx_q <= idx_q + 3'd1;
                    end else begin
                        cnt_q <= cnt_q + DIV_ONE;
                    end
                end
                RX_STOP: cnt_q <= bit_end ? '0 : cnt_q + DIV_ONE;
            endcase
        end
    end

    always_comb begin
        valid = valid_q;
        dout  = sh_q;
    end

endmodule

// File: rtl/uart_csr.sv
module uart_csr
    import byte_uart_pkg::*;
#(
    parameter int         DIV_W   = 20,
    parameter int         MIN_DIV = 16,
    parameter logic [7:0] ID_SEED = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [BUS_AW-1:0] paddr,
    input  logic [BUS_DW-1:0] pwdata,
    output logic [BUS_DW-1:0] prdata,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              tx_go,
    output logic [7:0]        tx_byte,
    output logic [DIV_W-1:0]  div,
    output logic              baud_ok,
    output logic [3:0]        irq_vec
);
    logic [CFG_W-1:0] cfg_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       tx_hold_q, rx_hold_q;
    logic             tx_full_q, rx_full_q, tx_ovr_q, rx_ovr_q;
    logic             irq_tx_q, irq_rx_q;

    logic [9:0] widx;
    logic       wr, rd, wr_byte, rd_byte, wr_flags, wr_irq, rx_take;
    logic       clr_txo, clr_rxo;
    logic [9:0] id_idx;
    logic       wd_unused;

    assign widx     = paddr[BUS_AW-1:2];
    assign wr       = psel & penable & pwrite;
    assign rd       = psel & penable & ~pwrite;
    assign wr_byte  = wr && widx == W_BYTE;
    assign rd_byte  = rd && widx == W_BYTE;
    assign wr_flags = wr && widx == W_FLAGS;
    assign wr_irq   = wr && widx == W_IRQ;
    assign clr_txo  = (wr_flags | wr_irq) & pwdata[2];
    assign clr_rxo  = (wr_flags | wr_irq) & pwdata[3];
    assign rx_take  = rx_valid & cfg_q[C_RX_EN];
    assign id_idx   = widx - W_ID0;
    assign wd_unused = &{1'b0, pwdata[BUS_DW-1:DIV_W], paddr[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            div_q     <= '0;
            tx_hold_q <= '0;
            rx_hold_q <= '0;
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
            tx_ovr_q  <= 1'b0;
            rx_ovr_q  <= 1'b0;
            irq_tx_q  <= 1'b0;
            irq_rx_q  <= 1'b0;
        end else begin
            if (wr && widx == W_CFG) cfg_q <= pwdata[CFG_W-1:0];
            if (wr && widx == W_DIV) div_q <= pwdata[DIV_W-1:0];
            if (wr_byte) tx_hold_q <= pwdata[7:0];

            if (wr_byte)      tx_full_q <= 1'b1;
            else if (tx_done) tx_full_q <= 1'b0;

            if (wr_byte && tx_full_q && !tx_done) tx_ovr_q <= 1'b1;
            else if (clr_txo)                     tx_ovr_q <= 1'b0;

            if (rx_take) rx_hold_q <= rx_byte;

            if (rx_take)      rx_full_q <= 1'b1;
            else if (rd_byte) rx_full_q <= 1'b0;

            if (rx_take && rx_full_q && !rd_byte) rx_ovr_q <= 1'b1;
            else if (clr_rxo)                     rx_ovr_q <= 1'b0;

            if (tx_done && cfg_q[C_TX_IE])  irq_tx_q <= 1'b1;
            else if (wr_irq && pwdata[0])   irq_tx_q <= 1'b0;

            if (rx_take && cfg_q[C_RX_IE])  irq_rx_q <= 1'b1;
            else if (wr_irq && pwdata[1])   irq_rx_q <= 1'b0;
        end
    end

    always_comb begin
        baud_ok = (div_q >= DIV_W'(MIN_DIV));
        tx_go   = cfg_q[C_TX_EN] & tx_full_q & baud_ok;
        tx_byte = tx_hold_q;
        div     = div_q;
        irq_vec = {rx_ovr_q & cfg_q[C_RXO_IE], tx_ovr_q & cfg_q[C_TXO_IE],
                   irq_rx_q, irq_tx_q};
    end

    always_comb begin
        prdata = '0;
        if (widx >= W_ID0) begin
            prdata[7:0] = ID_SEED + id_idx[7:0];
        end else begin
            case (widx)
                W_BYTE:  prdata[7:0]       = rx_hold_q;
                W_FLAGS: prdata[3:0]       = {rx_ovr_q, tx_ovr_q, rx_full_q, tx_full_q};
                W_CFG:   prdata[CFG_W-1:0] = cfg_q;
                W_IRQ:   prdata[3:0]       = irq_vec;
                W_DIV:   prdata[DIV_W-1:0] = div_q;
                default: prdata            = '0;
            endcase
        end
    end

endmodule

// File: rtl/apb_byte_uart.sv
module apb_byte_uart
    import byte_uart_pkg::*;
#(
    parameter int         DIV_W   = 20,
    parameter int         MIN_DIV = 16,
    parameter logic [7:0] ID_SEED = 8'hA0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [BUS_AW-1:0] paddr,
    input  logic [BUS_DW-1:0] pwdata,
    output logic [BUS_DW-1:0] prdata,
    output logic              pready,
    output logic              ser_out,
    input  logic              ser_in,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_tx_ovr,
    output logic              irq_rx_ovr,
    output logic              irq_any
);
    logic             tx_go, tx_done, rx_valid, baud_ok;
    logic [7:0]       tx_byte, rx_byte;
    logic [DIV_W-1:0] div;
    logic [3:0]       irq_vec;

    uart_csr #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV), .ID_SEED(ID_SEED)) u_csr (
        .clk(pclk), .rst_n(presetn),
        .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .tx_done(tx_done), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_go(tx_go), .tx_byte(tx_byte), .div(div),
        .baud_ok(baud_ok), .irq_vec(irq_vec)
    );

    uart_tx_fsm #(.DIV_W(DIV_W)) u_tx (
        .clk(pclk), .rst_n(presetn), .go(tx_go), .din(tx_byte),
        .div(div), .ser_out(ser_out), .done(tx_done)
    );

    uart_rx_fsm #(.DIV_W(DIV_W), .SYNC_N(2)) u_rx (
        .clk(pclk), .rst_n(presetn), .ser_in(ser_in), .enable(baud_ok),
        .div(div), .valid(rx_valid), .dout(rx_byte)
    );

    always_comb begin
        pready     = 1'b1;
        irq_tx     = irq_vec[0];
        irq_rx     = irq_vec[1];
        irq_tx_ovr = irq_vec[2];
        irq_rx_ovr = irq_vec[3];
        irq_any    = |irq_vec;
    end

endmodule

// File: rtl/apb_byte_uart_sva.sv
module apb_byte_uart_sva (
    input logic        pclk,
    input logic        presetn,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [11:0] paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        pready,
    input logic        irq_tx,
    input logic        irq_rx,
    input logic        irq_tx_ovr,
    input logic        irq_rx_ovr,
    input logic        irq_any
);
    logic rd_irq, wr_irq;
    assign rd_irq = psel && penable && !pwrite && paddr == 12'h00C;
    assign wr_irq = psel && penable && pwrite && paddr == 12'h00C;

    a_r13_pready_high: assert property (@(posedge pclk) disable iff (!presetn)
        pready);

    a_r12_lines_match_reg: assert property (@(posedge pclk) disable iff (!presetn)
        rd_irq |-> prdata[3:0] == {irq_rx_ovr, irq_tx_ovr, irq_rx, irq_tx});

    a_r12_any_match_reg: assert property (@(posedge pclk) disable iff (!presetn)
        rd_irq |-> (prdata[3:0] != 4'h0) == irq_any);

    a_r11_txo_ack_clears: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_irq && pwdata[2]) |=> !irq_tx_ovr);

    a_r6_tx_irq_sticky: assert property (@(posedge pclk) disable iff (!presetn)
        (irq_tx && !(wr_irq && pwdata[0])) |=> irq_tx);

endmodule

bind apb_byte_uart apb_byte_uart_sva u_sva (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_tx_ovr(irq_tx_ovr), .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any)
);

// File: tb/apb_byte_uart_bench.sv
`timescale 1ns/1ps
module apb_byte_uart_bench;
    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, ser_out, ser_in;
    logic        irq_tx, irq_rx, irq_tx_ovr, irq_rx_ovr, irq_any;
    logic        loop = 1'b0, drv = 1'b1;

    int checks = 0, errors = 0, cyc = 0;
    bit ended = 0;

    always #10 pclk = ~pclk;
    assign ser_in = loop ? ser_out : drv;

    apb_byte_uart u_apb_byte_uart (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .ser_out(ser_out), .ser_in(ser_in),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_tx_ovr(irq_tx_ovr),
        .irq_rx_ovr(irq_rx_ovr), .irq_any(irq_any)
    );

    always @(posedge pclk) begin
        cyc <= cyc + 1;
        if (cyc == 190000 && !ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge pclk) #1;
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(posedge pclk) #1;
        penable = 1;
        @(posedge pclk) #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge pclk) #1;
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(posedge pclk) #1;
        penable = 1;
        @(negedge pclk);
        d = prdata;
        @(posedge pclk) #1;
        psel = 0; penable = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic wait_low(input string tag);
        int t = 0;
        @(negedge pclk);
        while (ser_out !== 1'b0 && t < 5000) begin
            @(negedge pclk);
            t++;
        end
        if (t >= 5000) chk({tag, " start timeout"}, 32'h1, 32'h0);
    endtask

    task automatic decode_tx(input string tag, input int div, input logic [7:0] exp);
        logic [7:0] b;
        logic       st, sp;
        wait_low(tag);
        repeat (div / 2) @(negedge pclk);
        st = ser_out;
        for (int i = 0; i < 8; i++) begin
            repeat (div) @(negedge pclk);
            b[i] = ser_out;
        end
        repeat (div) @(negedge pclk);
        sp = ser_out;
        chk({tag, " frame"}, {22'h0, sp, b, st}, {22'h0, 1'b1, exp, 1'b0});
    endtask

    task automatic start_len(input string tag, input int div);
        int n = 0;
        wait_low(tag);
        while (ser_out === 1'b0 && n < 5000) begin
            n++;
            @(negedge pclk);
        end
        chk(tag, n, div);
    endtask

    task automatic wait_tx_empty();
        logic [31:0] d;
        for (int k = 0; k < 200; k++) begin
            apb_rd(12'h004, d);
            if (d[0] == 1'b0) break;
        end
    endtask

    task automatic drive_frame(input int div, input logic [7:0] b, input logic stop);
        @(posedge pclk) #1;
        drv = 0;
        repeat (div) @(posedge pclk);
        #1;
        for (int i = 0; i < 8; i++) begin
            drv = b[i];
            repeat (div) @(posedge pclk);
            #1;
        end
        drv = stop;
        repeat (div) @(posedge pclk);
        #1;
        drv = 1;
        repeat (div) @(posedge pclk);
    endtask

    initial begin
        logic [31:0] d;
        int          bad;
        repeat (3) @(posedge pclk);
        #1 presetn = 1;
        @(negedge pclk);

        // R1 reset state
        chk("R1 ser_out idle", ser_out, 1);
        chk("R1 irq lines", {irq_any, irq_rx_ovr, irq_tx_ovr, irq_rx, irq_tx}, 0);
        for (int r = 0; r < 5; r++) rd_chk("R1 register zero", 12'(r * 4), 0);
        chk("R13 pready", pready, 1);

        // R2 identification words and unmapped offsets
        for (int i = 0; i < 12; i++) rd_chk("R2 id word", 12'hFD0 + 12'(i * 4), 32'hA0 + i);
        apb_wr(12'hFD0, 32'h55);
        rd_chk("R2 id write ignored", 12'hFD0, 32'hA0);
        rd_chk("R2 unmapped 0x14", 12'h014, 0);
        rd_chk("R2 unmapped 0x800", 12'h800, 0);

        // R3 / R4 register widths
        apb_wr(12'h008, 32'hFFFF_FFFF);
        rd_chk("R3 config mask", 12'h008, 32'h7F);
        apb_wr(12'h008, 0);
        apb_wr(12'h010, 32'hFFFF_FFFF);
        rd_chk("R4 divider mask", 12'h010, 32'hFFFFF);

        // R4 invalid divider keeps transmitter idle
        apb_wr(12'h010, 15);
        apb_wr(12'h008, 32'h01);
        apb_wr(12'h000, 32'h5A);
        bad = 0;
        repeat (200) begin
            @(negedge pclk);
            if (ser_out !== 1'b1) bad = 1;
        end
        chk("R4 idle with divider 15", bad, 0);
        rd_chk("R4 byte still held", 12'h004, 32'h1);
        apb_wr(12'h010, 16);
        decode_tx("R5 after divider valid", 16, 8'h5A);
        wait_tx_empty();

        // R5 bit time at two divider values
        apb_wr(12'h000, 32'h01);
        start_len("R5 start bit length 16", 16);
        wait_tx_empty();
        apb_wr(12'h010, 20);
        apb_wr(12'h000, 32'h01);
        start_len("R5 start bit length 20", 20);
        wait_tx_empty();
        apb_wr(12'h010, 16);

        // R6 transmit interrupt
        apb_wr(12'h008, 32'h05);
        apb_wr(12'h000, 32'hC5);
        decode_tx("R6 frame", 16, 8'hC5);
        wait_tx_empty();
        @(negedge pclk);
        chk("R6 irq_tx set", irq_tx, 1);
        chk("R12 irq_any follows", irq_any, 1);
        rd_chk("R6 irq register", 12'h00C, 32'h1);
        apb_wr(12'h00C, 32'h1);
        @(negedge pclk);
        chk("R6 irq_tx cleared", irq_tx, 0);
        chk("R12 irq_any cleared", irq_any, 0);
        apb_wr(12'h008, 32'h01);
        apb_wr(12'h000, 32'h3C);
        decode_tx("R6 frame no enable", 16, 8'h3C);
        wait_tx_empty();
        @(negedge pclk);
        chk("R6 no irq without enable", irq_tx, 0);

        // R7 / R11 transmit overrun
        apb_wr(12'h008, 32'h00);
        apb_wr(12'h000, 32'h11);
        apb_wr(12'h000, 32'h22);
        rd_chk("R7 overrun flag", 12'h004, 32'h5);
        apb_wr(12'h008, 32'h10);
        @(negedge pclk);
        chk("R11 irq_tx_ovr live", irq_tx_ovr, 1);
        rd_chk("R11 irq bit2", 12'h00C, 32'h4);
        apb_wr(12'h00C, 32'h4);
        rd_chk("R11 ack clears flag", 12'h004, 32'h1);
        @(negedge pclk);
        chk("R11 irq_tx_ovr low", irq_tx_ovr, 0);
        apb_wr(12'h000, 32'h33);
        rd_chk("R7 overrun again", 12'h004, 32'h5);
        apb_wr(12'h004, 32'h4);
        rd_chk("R7 flags w1c", 12'h004, 32'h1);
        apb_wr(12'h008, 32'h01);
        decode_tx("R7 replaced byte sent", 16, 8'h33);
        wait_tx_empty();
        rd_chk("R7 flags after send", 12'h004, 32'h0);

        // R5 / R8 exhaustive loopback
        loop = 1;
        apb_wr(12'h008, 32'h03);
        for (int b = 0; b < 256; b++) begin
            apb_wr(12'h000, 32'(b));
            decode_tx("R5 loopback tx", 16, 8'(b));
            repeat (32) @(negedge pclk);
            rd_chk("R8 loopback rx", 12'h000, 32'(b));
        end
        loop = 0;
        repeat (40) @(negedge pclk);

        // R8 driven frames at two divider values
        apb_wr(12'h008, 32'h0A);
        foreach (bad_dummy_vals[j]) ;
        for (int dv = 0; dv < 2; dv++) begin
            int div = (dv == 0) ? 16 : 23;
            apb_wr(12'h010, 32'(div));
            for (int p = 0; p < 4; p++) begin
                logic [7:0] v;
                v = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'hA5 : 8'h5A;
                drive_frame(div, v, 1'b1);
                rd_chk("R8 rx full", 12'h004, 32'h2);
                rd_chk("R8 rx byte", 12'h000, {24'h0, v});
                rd_chk("R8 read clears full", 12'h004, 32'h0);
            end
        end
        apb_wr(12'h010, 16);
        @(negedge pclk);
        chk("R8 irq_rx set", irq_rx, 1);
        apb_wr(12'h00C, 32'h2);
        @(negedge pclk);
        chk("R8 irq_rx cleared", irq_rx, 0);
        drive_frame(16, 8'h3C, 1'b0);
        rd_chk("R8 bad stop dropped", 12'h004, 32'h0);
        @(posedge pclk) #1 drv = 0;
        repeat (4) @(posedge pclk);
        #1 drv = 1;
        repeat (60) @(posedge pclk);
        rd_chk("R8 glitch ignored", 12'h004, 32'h0);

        // R10 receive overrun
        apb_wr(12'h008, 32'h22);
        drive_frame(16, 8'h12, 1'b1);
        drive_frame(16, 8'h34, 1'b1);
        rd_chk("R10 overrun flags", 12'h004, 32'hA);
        @(negedge pclk);
        chk("R11 irq_rx_ovr live", irq_rx_ovr, 1);
        rd_chk("R11 irq bit3", 12'h00C, 32'h8);
        rd_chk("R10 overwritten byte", 12'h000, 32'h34);
        apb_wr(12'h00C, 32'h8);
        rd_chk("R11 rx overrun acked", 12'h004, 32'h0);
        @(negedge pclk);
        chk("R12 all lines low", irq_any, 0);

        // R9 receive disabled
        apb_wr(12'h008, 32'h00);
        drive_frame(16, 8'h77, 1'b1);
        rd_chk("R9 flags untouched", 12'h004, 32'h0);
        rd_chk("R9 buffer untouched", 12'h000, 32'h34);

        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int bad_dummy_vals[1];

endmodule